// File: doc/BRIEF.md
# Add-One Carry-Select Adder

This block adds two unsigned binary operands of a parameterised width together with a single carry-in. It returns the sum and a carry-out. It is purely combinational, so there is no valid/ready handshake and no back-pressure. Its pins are plain data that settle within one combinational path.

The operands are cut into 4-bit slices. Each slice has one adder, and that adder always assumes a carry-in of zero. A cheap correction stage then turns the slice's zero-carry result into the real result. It does this by XOR-ing each bit with the AND of the slice's actual carry-in and all lower bits of the zero-carry result. The choice between the two possible results is folded into those XOR gates, so the slice needs no second adder and no multiplexer. A slice whose zero-carry result is all ones passes an incoming carry straight through. That all-ones condition is the slice's propagate term for the carry network between slices.

The `STYLE` parameter chooses between two carry structures:
- `CHAIN_RIPPLE`: full-adder ripple slices, with the slice carries passed linearly from slice to slice.
- `CHAIN_TREE`: lookahead slices, with a prefix generate/propagate tree across the slices. The tree's depth grows with the logarithm of the slice count.

Top module: `a1s_adder`

## Requirements
- R1: For every input, {carry_out, sum} equals the full-precision value a + b + carry_in, which is WIDTH+1 bits wide.
- R2: Each 4-bit slice adder produces the slice sum and slice carry for a carry-in of zero only. A carry that leaves slice 0 with carry_in = 0 appears as bit 4 of the result (12 + 4 = 0x10).
- R3: When a slice's actual carry-in is 0, its output bits equal its zero-carry result unchanged. For example, 8-bit 12 + 4 with carry_in 0 gives 0x10 and carry_out 0, and all-ones + 0 with carry_in 0 gives all-ones and carry_out 0.
- R4: When a slice's carry-in is 1 and its zero-carry result has m trailing ones, the lowest m+1 bits are inverted and the rest are kept. Examples: 1 + 6 gives 0111 with carry_in 0 and 1000 with carry_in 1, and 12 + 4 with carry_in 1 gives 0x11.
- R5: A slice's outgoing carry is its zero-carry carry-out OR (its incoming carry AND the all-ones test of its zero-carry result). All-ones + 0 with carry_in 1 therefore yields sum 0 and carry_out 1 across every slice.
- R6: The CHAIN_RIPPLE (STYLE = 0) and CHAIN_TREE (STYLE = 1) variants give identical sum and carry_out for identical inputs.
- R7: WIDTH is any multiple of 4 from 8 to 256. The 8-bit and 64-bit configurations both meet R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the least significant slice |
| sum | output | WIDTH | Low WIDTH bits of the result |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
The embedded checks are immediate assertions inside combinational processes. They take for granted that every input bit holds a definite 0 or 1 whenever the logic is evaluated, and that they judge settled values, not intermediate ones. The stimulus keeps to this in two ways. It drives every operand and carry bit with a fully specified two-state value. It samples one time unit after each change, never at the instant of the change, so each comparison sees a stable combinational result.

// File: rtl/a1csa_pkg.sv
package a1csa_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef enum logic {
    CHAIN_RIPPLE = 1'b0,
    CHAIN_TREE   = 1'b1
  } carry_style_e;
endpackage

// File: rtl/a1s_slice_add.sv
// 4-bit adder with carry-in tied to zero; structure chosen by STYLE.
module a1s_slice_add
  import a1csa_pkg::*;
#(
  parameter carry_style_e STYLE = CHAIN_TREE
) (
  input  logic [SLICE_W-1:0] x,
  input  logic [SLICE_W-1:0] y,
  output logic [SLICE_W-1:0] r,
  output logic               co
);
  logic [SLICE_W-1:0] bg, bp;
  assign bg = x & y;
  assign bp = x ^ y;

  if (STYLE == CHAIN_RIPPLE) begin : g_ripple
    logic [SLICE_W:0] rc;
    assign rc[0] = 1'b0;
    for (genvar i = 0; i < SLICE_W; i++) begin : g_fa
      assign r[i]    = bp[i] ^ rc[i];
      assign rc[i+1] = bg[i] | (bp[i] & rc[i]);
    end
    assign co = rc[SLICE_W];
  end else begin : g_look
    logic c1, c2, c3;
    assign c1 = bg[0];
    assign c2 = bg[1] | (bp[1] & bg[0]);
    assign c3 = bg[2] | (bp[2] & bg[1]) | (bp[2] & bp[1] & bg[0]);
    assign co = bg[3] | (bp[3] & bg[2]) | (bp[3] & bp[2] & bg[1])
              | (bp[3] & bp[2] & bp[1] & bg[0]);
    assign r  = bp ^ {c3, c2, c1, 1'b0};
  end

  // The slice must model a zero carry-in addition
  always_comb begin
    assert_zero_cin_sum_R2: assert ({co, r} == ({1'b0, x} + {1'b0, y}))
      else $error("slice zero-carry sum wrong");
  end
endmodule

// File: rtl/a1s_fold_fix.sv
// Add-one correction with selection merged into the XOR gates.
module a1s_fold_fix
  import a1csa_pkg::*;
(
  input  logic [SLICE_W-1:0] r,
  input  logic               c,
  output logic [SLICE_W-1:0] s,
  output logic               p
);
  logic [SLICE_W:0] pre;
  assign pre[0] = c;
  for (genvar i = 0; i < SLICE_W; i++) begin : g_pre
    assign pre[i+1] = pre[i] & r[i];
  end
  assign s = r ^ pre[SLICE_W-1:0];
  assign p = &r;

  logic [SLICE_W-1:0] flip;
  assign flip = s ^ r;

  always_comb begin
    if (!c) begin
      assert_pass_through_R3: assert (flip == '0)
        else $error("slice altered with zero carry-in");
    end else if (r == {SLICE_W{1'b1}}) begin
      assert_full_invert_R4: assert (flip == {SLICE_W{1'b1}})
        else $error("all-ones slice not fully inverted");
    end else begin
      assert_low_run_flip_R4: assert ((flip != '0) && (((flip + 1'b1) & flip) == '0)
                                      && ((r & flip) == (flip >> 1)))
        else $error("flipped bits are not trailing ones plus one");
    end
  end
endmodule

// File: rtl/a1s_carry_net.sv
// Slice-to-slice carry network: linear chain or prefix tree.
module a1s_carry_net
  import a1csa_pkg::*;
#(
  parameter int unsigned   NSL   = 8,
  parameter carry_style_e  STYLE = CHAIN_TREE
) (
  input  logic [NSL-1:0] gen,
  input  logic [NSL-1:0] prop,
  input  logic           cin,
  output logic [NSL:0]   mc
);
  localparam int unsigned LV = (NSL > 1) ? $clog2(NSL) : 0;

  assign mc[0] = cin;

  if (STYLE == CHAIN_RIPPLE) begin : g_chain
    for (genvar i = 0; i < NSL; i++) begin : g_link
      assign mc[i+1] = gen[i] | (prop[i] & mc[i]);
    end
  end else begin : g_tree
    for (genvar l = 0; l <= LV; l++) begin : lvl
      logic [NSL-1:0] tg, tp;
      if (l == 0) begin : g_base
        assign tg = {gen[NSL-1:1], gen[0] | (prop[0] & cin)};
        assign tp = prop;
      end else begin : g_comb
        localparam int unsigned D = 1 << (l - 1);
        for (genvar i = 0; i < NSL; i++) begin : g_node
          if (i >= D) begin : g_mix
            assign tg[i] = lvl[l-1].tg[i] | (lvl[l-1].tp[i] & lvl[l-1].tg[i-D]);
            assign tp[i] = lvl[l-1].tp[i] & lvl[l-1].tp[i-D];
          end else begin : g_keep
            assign tg[i] = lvl[l-1].tg[i];
            assign tp[i] = lvl[l-1].tp[i];
          end
        end
      end
    end
    assign mc[NSL:1] = lvl[LV].tg;

    // Tree result must agree with the per-slice carry recurrence
    always_comb begin
      for (int i = 0; i < NSL; i++) begin
        assert_slice_carry_R5: assert (mc[i+1] == (gen[i] | (prop[i] & mc[i])))
          else $error("tree carry disagrees at slice %0d", i);
      end
    end
  end
endmodule

// File: rtl/a1s_adder.sv
module a1s_adder
  import a1csa_pkg::*;
#(
  parameter int unsigned  WIDTH = 32,
  parameter carry_style_e STYLE = CHAIN_TREE
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int unsigned NSL = WIDTH / SLICE_W;

  logic [NSL-1:0]   sl_gen, sl_prop;
  logic [NSL:0]     sl_c;
  logic [WIDTH-1:0] raw;

  for (genvar k = 0; k < NSL; k++) begin : g_slice
    a1s_slice_add #(.STYLE(STYLE)) u_add (
      .x  (a[k*SLICE_W +: SLICE_W]),
      .y  (b[k*SLICE_W +: SLICE_W]),
      .r  (raw[k*SLICE_W +: SLICE_W]),
      .co (sl_gen[k])
    );
    a1s_fold_fix u_fix (
      .r (raw[k*SLICE_W +: SLICE_W]),
      .c (sl_c[k]),
      .s (sum[k*SLICE_W +: SLICE_W]),
      .p (sl_prop[k])
    );
  end

  a1s_carry_net #(.NSL(NSL), .STYLE(STYLE)) u_net (
    .gen  (sl_gen),
    .prop (sl_prop),
    .cin  (carry_in),
    .mc   (sl_c)
  );

  assign carry_out = sl_c[NSL];

  always_comb begin
    assert_total_R1: assert ({carry_out, sum} ==
                             ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("adder result wrong");
  end
endmodule

// File: tb/a1s_adder_tb.sv
`timescale 1ns/1ps
module a1s_adder_tb;
  import a1csa_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int n_vec  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [63:0] wa, wb, wt_s, wr_s;
  logic        wc, wt_c, wr_c;
  logic [7:0]  na, nb, nt_s, nr_s;
  logic        nc, nt_c, nr_c;

  a1s_adder #(.WIDTH(64), .STYLE(CHAIN_TREE)) u_dut (
    .a(wa), .b(wb), .carry_in(wc), .sum(wt_s), .carry_out(wt_c));
  a1s_adder #(.WIDTH(64), .STYLE(CHAIN_RIPPLE)) u_dut_rip (
    .a(wa), .b(wb), .carry_in(wc), .sum(wr_s), .carry_out(wr_c));
  a1s_adder #(.WIDTH(8), .STYLE(CHAIN_TREE)) u_dut_n8t (
    .a(na), .b(nb), .carry_in(nc), .sum(nt_s), .carry_out(nt_c));
  a1s_adder #(.WIDTH(8), .STYLE(CHAIN_RIPPLE)) u_dut_n8r (
    .a(na), .b(nb), .carry_in(nc), .sum(nr_s), .carry_out(nr_c));

  task automatic check(input string tag, input logic [64:0] got, input logic [64:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run64(input string tag, input logic [63:0] x, input logic [63:0] y,
                       input logic c);
    logic [64:0] ref_v;
    wa = x; wb = y; wc = c;
    #1;
    ref_v = {1'b0, x} + {1'b0, y} + {64'd0, c};
    check({tag, " tree"},   {wt_c, wt_s}, ref_v);
    check({tag, " ripple"}, {wr_c, wr_s}, ref_v);
  endtask

  task automatic run8(input string tag, input logic [7:0] x, input logic [7:0] y,
                      input logic c, input logic [8:0] exp);
    na = x; nb = y; nc = c;
    #1;
    check({tag, " tree8"},   {56'd0, nt_c, nt_s}, {56'd0, exp});
    check({tag, " ripple8"}, {56'd0, nr_c, nr_s}, {56'd0, exp});
  endtask

  // R1: all-zero inputs give a zero result
  task automatic t_idle_state();
    run64("R1 idle", 64'd0, 64'd0, 1'b0);
    run8("R1 idle", 8'd0, 8'd0, 1'b0, 9'h000);
  endtask

  // R2, R3, R4: fixed example vectors
  task automatic t_examples();
    run8("R2 12+4 c0", 8'd12, 8'd4, 1'b0, 9'h010);
    run8("R3 12+4 c0", 8'd12, 8'd4, 1'b0, 9'h010);
    run8("R4 12+4 c1", 8'd12, 8'd4, 1'b1, 9'h011);
    run8("R4 1+6 c0",  8'd1,  8'd6, 1'b0, 9'h007);
    run8("R4 1+6 c1",  8'd1,  8'd6, 1'b1, 9'h008);
    run8("R4 trail3",  8'h07, 8'h00, 1'b1, 9'h008);
    run8("R4 nibflip", 8'h0F, 8'h00, 1'b1, 9'h010);
  endtask

  // R3, R5: all-ones operand ripples a carry through every slice
  task automatic t_all_ones();
    run64("R3 ones c0", {64{1'b1}}, 64'd0, 1'b0);
    run64("R5 ones c1", {64{1'b1}}, 64'd0, 1'b1);
    run8("R5 ones c1", 8'hFF, 8'h00, 1'b1, 9'h100);
    run8("R3 ones c0", 8'hFF, 8'h00, 1'b0, 9'h0FF);
  endtask

  // R6: alternating patterns, both variants against the same reference
  task automatic t_alternating();
    run64("R6 alt c0", {16{4'h5}}, {16{4'hA}}, 1'b0);
    run64("R6 alt c1", {16{4'h5}}, {16{4'hA}}, 1'b1);
    run64("R6 alt2",   {16{4'hA}}, {16{4'hA}}, 1'b1);
    run64("R6 alt3",   {8{8'h0F}}, {8{8'hF1}}, 1'b0);
  endtask

  // R1, R7: exhaustive 8-bit configuration
  task automatic t_exhaustive8();
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++)
          run8("R7 exh", x[7:0], y[7:0], c[0], 9'(x + y + c));
  endtask

  // R1, R6: random wide vectors
  task automatic t_random64();
    for (int i = 0; i < 4000; i++)
      run64("R1 rnd", {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    wa = '0; wb = '0; wc = 1'b0;
    na = '0; nb = '0; nc = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_idle_state();
    t_examples();
    t_all_ones();
    t_alternating();
    t_exhaustive8();
    t_random64();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule